// File: doc/BRIEF.md
# Packed Lane Funnel Shifter

This vector datapath unit treats a 512-bit register image as a row of equal lanes. The lane width is chosen at run time and can be 16, 32 or 64 bits. In each lane it places a lane of the high source above the matching lane of the low source. It shifts that double-width value right by an immediate count and keeps the low lane-width bits. A lane write mask then decides lane by lane whether the shifted value is written. A lane that is not written is either zeroed or keeps the prior destination value. Everything above the selected vector length is cleared.

An issue stage presents both sources, the old destination image, the immediate and the control selects together with a valid strobe. One clock later the unit returns the finished 512-bit image and an echoed valid. An optional broadcast mode takes the high half of every lane from lane 0 of the high source.

Top module: `lane_funnel_shifter`

## Requirements
- R1: For each active lane, the result is the low lane-width bits of the concatenation {hi_src lane, lo_src lane} shifted right logically. Lane j occupies bits [j*W +: W], where W is the lane width.
- R2: The shift count is the immediate masked to its low log2(W) bits: 4 bits for 16-bit lanes, 5 bits for 32-bit lanes and 6 bits for 64-bit lanes. Higher immediate bits have no effect.
- R3: esize_i selects the lane width: code 0 is 16 bits, code 1 is 32 bits, and codes 2 and 3 are 64 bits. When masking is on, mask_i bit j governs lane j.
- R4: With mask_en_i low, every active lane is written with its shifted value, whatever mask_i holds.
- R5: With mask_en_i high and zero_en_i high, an active lane whose mask bit is 0 is written with zero.
- R6: With mask_en_i high and zero_en_i low, an active lane whose mask bit is 0 takes its value from the same lane of dst_old_i.
- R7: With bcast_i high and 32-bit or 64-bit lanes, lane 0 of hi_src_i is the high half for every lane.
- R8: With bcast_i high and 16-bit lanes, the broadcast request is ignored and each lane uses its own hi_src lane.
- R9: vlen_i selects the vector length: code 0 is 128 bits, code 1 is 256 bits, and codes 2 and 3 are 512 bits. All result bits at and above that length are zero, whatever the mask, zeroing and dst_old_i inputs hold.
- R10: The result is registered. When valid_i is high at a clock edge, res_o and valid_o reflect that request after the edge. When valid_i is low, valid_o falls and res_o holds its value. A synchronous active-high rst clears res_o and valid_o.
- R11: A masked shift count of zero returns the lo_src lane unchanged. An example is an immediate of 64 with 64-bit lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| lo_src_i | input | 512 | Source placed in the low half of each lane pair |
| hi_src_i | input | 512 | Source placed in the high half of each lane pair |
| dst_old_i | input | 512 | Prior destination image used for merge masking |
| imm_i | input | 8 | Shift immediate |
| esize_i | input | 2 | Lane width code |
| vlen_i | input | 2 | Vector length code |
| mask_i | input | 32 | Per-lane write mask |
| mask_en_i | input | 1 | Enables the write mask |
| zero_en_i | input | 1 | Zero masked-off lanes instead of merging |
| bcast_i | input | 1 | Use lane 0 of hi_src_i for every lane |
| valid_o | output | 1 | Echoed request strobe |
| res_o | output | 512 | Registered result image |

## Verification
The bench builds the unit with its default 512-bit data width and 8-bit immediate. That configuration makes all three lane widths and all three vector lengths reachable. It also exercises the full 32-bit mask, so every mask bit in 16-bit mode and the unused upper mask bits in 64-bit mode can be driven. Immediates with bits set above each lane's count field test the count masking at every width. Every result is compared with a reference model written in the bench.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   localparam int GRAN_W = 16;

   typedef enum logic [1:0] {
      ESZ_16  = 2'd0,
      ESZ_32  = 2'd1,
      ESZ_64  = 2'd2,
      ESZ_64B = 2'd3
   } esize_e;

   typedef enum logic [1:0] {
      VL_128  = 2'd0,
      VL_256  = 2'd1,
      VL_512  = 2'd2,
      VL_512B = 2'd3
   } vlen_e;
endpackage

// File: rtl/lfs_width_path.sv
module lfs_width_path #(
   parameter int DATA_W   = 512,
   parameter int EW       = 64,
   parameter int IMM_W    = 8,
   parameter bit BCAST_OK = 1'b1
) (
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              bcast_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int LANES = DATA_W / EW;
   localparam int SH_W  = $clog2(EW);

   if (SH_W > IMM_W) begin : g_bad_imm
      $error("immediate too narrow for lane width");
   end

   logic [SH_W-1:0] sh;
   assign sh = imm_i[SH_W-1:0];

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [EW-1:0]   hi_sel;
      logic [2*EW-1:0] joined;
      logic [2*EW-1:0] shifted;

      if (BCAST_OK) begin : g_bc
         assign hi_sel = bcast_i ? hi_i[EW-1:0] : hi_i[j*EW +: EW];
      end else begin : g_nobc
         assign hi_sel = hi_i[j*EW +: EW];
      end

      assign joined  = {hi_sel, lo_i[j*EW +: EW]};
      assign shifted = joined >> sh;
      assign res_o[j*EW +: EW] = shifted[EW-1:0];
   end
endmodule

// File: rtl/lfs_merge.sv
module lfs_merge #(
   parameter int DATA_W = 512,
   parameter int GRAN_W = 16
) (
   input  logic [DATA_W-1:0]        cand_i,
   input  logic [DATA_W-1:0]        old_i,
   input  logic [1:0]               esize_i,
   input  logic [1:0]               vlen_i,
   input  logic [DATA_W/GRAN_W-1:0] mask_i,
   input  logic                     mask_en_i,
   input  logic                     zero_en_i,
   output logic [DATA_W-1:0]        res_o
);
   localparam int NGRAN   = DATA_W / GRAN_W;
   localparam int IDX_W   = $clog2(NGRAN) + 1;
   localparam int G_128   = 128 / GRAN_W;

   logic [1:0]       lane_sh;
   logic [IDX_W-1:0] act_gran;

   always_comb begin
      case (esize_i)
         2'd0:    lane_sh = 2'd0;
         2'd1:    lane_sh = 2'd1;
         default: lane_sh = 2'd2;
      endcase
      case (vlen_i)
         2'd0:    act_gran = IDX_W'(G_128);
         2'd1:    act_gran = IDX_W'(G_128 * 2);
         default: act_gran = IDX_W'(G_128 * 4);
      endcase
   end

   for (genvar g = 0; g < NGRAN; g++) begin : g_gran
      logic [IDX_W-1:0] lane_idx;
      logic             active;
      logic             wr;
      assign lane_idx = IDX_W'(g) >> lane_sh;
      assign active   = IDX_W'(g) < act_gran;
      assign wr       = !mask_en_i || mask_i[lane_idx[IDX_W-2:0]];
      assign res_o[g*GRAN_W +: GRAN_W] =
         !active   ? '0 :
         wr        ? cand_i[g*GRAN_W +: GRAN_W] :
         zero_en_i ? '0 : old_i[g*GRAN_W +: GRAN_W];
   end
endmodule

// File: rtl/lane_funnel_shifter.sv
module lane_funnel_shifter #(
   parameter int DATA_W = 512,
   parameter int IMM_W  = 8,
   localparam int MASK_W = DATA_W / lfs_pkg::GRAN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] lo_src_i,
   input  logic [DATA_W-1:0] hi_src_i,
   input  logic [DATA_W-1:0] dst_old_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [1:0]        esize_i,
   input  logic [1:0]        vlen_i,
   input  logic [MASK_W-1:0] mask_i,
   input  logic              mask_en_i,
   input  logic              zero_en_i,
   input  logic              bcast_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] res_o
);
   import lfs_pkg::*;

   localparam int NWID = 3;

   if (DATA_W != 512) begin : g_bad_width
      $error("DATA_W must be 512");
   end
   if (IMM_W < 6) begin : g_bad_imm
      $error("IMM_W must hold a 64-bit lane count");
   end

   logic [DATA_W-1:0] cand [NWID];
   logic [DATA_W-1:0] sel;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] res_q;
   logic              vld_q;

   for (genvar w = 0; w < NWID; w++) begin : g_wid
      lfs_width_path #(
         .DATA_W  (DATA_W),
         .EW      (GRAN_W << w),
         .IMM_W   (IMM_W),
         .BCAST_OK(w != 0)
      ) u_path (
         .lo_i   (lo_src_i),
         .hi_i   (hi_src_i),
         .imm_i  (imm_i),
         .bcast_i(bcast_i),
         .res_o  (cand[w])
      );
   end

   always_comb begin
      case (esize_e'(esize_i))
         ESZ_16:  sel = cand[0];
         ESZ_32:  sel = cand[1];
         default: sel = cand[2];
      endcase
   end

   lfs_merge #(.DATA_W(DATA_W), .GRAN_W(GRAN_W)) u_merge (
      .cand_i   (sel),
      .old_i    (dst_old_i),
      .esize_i  (esize_i),
      .vlen_i   (vlen_i),
      .mask_i   (mask_i),
      .mask_en_i(mask_en_i),
      .zero_en_i(zero_en_i),
      .res_o    (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= valid_i;
         if (valid_i) res_q <= merged;
      end
   end

   assign res_o   = res_q;
   assign valid_o = vld_q;

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (res_o == '0 && !valid_o));

   p_valid_echo_r10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> valid_o == $past(valid_i));

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(res_o));

   p_vl128_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (valid_i && vlen_i == 2'd0) |=> res_o[DATA_W-1:128] == '0);

   p_all_zeroed_r5: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mask_en_i && zero_en_i && mask_i == '0) |=> res_o == '0);

   p_all_merged_r6: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mask_en_i && !zero_en_i && mask_i == '0 && vlen_i[1])
      |=> res_o == $past(dst_old_i));

   p_zero_count_r11: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !mask_en_i && esize_i[1] && vlen_i[1] && imm_i[5:0] == 6'd0)
      |=> res_o == $past(lo_src_i));
endmodule

// File: tb/lane_funnel_shifter_test.sv
module lane_funnel_shifter_test;
   localparam int CLK_P = 10;
   localparam int DW    = 512;

   logic          clk = 1'b0;
   logic          rst;
   logic          valid_i;
   logic [DW-1:0] lo, hi, old;
   logic [7:0]    imm;
   logic [1:0]    esz, vl;
   logic [31:0]   mask;
   logic          men, zen, bc;
   logic          valid_o;
   logic [DW-1:0] res_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lane_funnel_shifter uut (
      .clk(clk), .rst(rst), .valid_i(valid_i),
      .lo_src_i(lo), .hi_src_i(hi), .dst_old_i(old), .imm_i(imm),
      .esize_i(esz), .vlen_i(vl), .mask_i(mask), .mask_en_i(men),
      .zero_en_i(zen), .bcast_i(bc), .valid_o(valid_o), .res_o(res_o)
   );

   function automatic logic [DW-1:0] pat(input int seed);
      logic [31:0]   s;
      logic [DW-1:0] v;
      s = 32'h9E37_79B9 ^ 32'(seed * 7919);
      v = '0;
      for (int k = 0; k < DW/32; k++) begin
         s = s * 32'd1664525 + 32'd1013904223;
         v[k*32 +: 32] = s;
      end
      return v;
   endfunction

   function automatic logic [DW-1:0] model();
      int            ew, vlb, nl, sh;
      logic [63:0]   lm, lo_l, hi_l, old_l, r;
      logic [127:0]  cat;
      logic [DW-1:0] out;
      ew  = (esz == 2'd0) ? 16 : (esz == 2'd1) ? 32 : 64;
      vlb = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
      nl  = vlb / ew;
      lm  = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
      sh  = int'(imm) & (ew - 1);
      out = '0;
      for (int j = 0; j < DW/ew; j++) begin
         lo_l  = 64'(lo >> (j*ew)) & lm;
         old_l = 64'(old >> (j*ew)) & lm;
         hi_l  = (bc && ew != 16) ? (64'(hi) & lm) : (64'(hi >> (j*ew)) & lm);
         cat   = (128'(hi_l) << ew) | 128'(lo_l);
         r     = 64'(cat >> sh) & lm;
         if (j >= nl) r = '0;
         else if (men && !mask[j]) r = zen ? 64'd0 : old_l;
         out = out | (DW'(r) << (j*ew));
      end
      return out;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run(input string tag);
      logic [DW-1:0] e;
      e = model();
      @(negedge clk) valid_i = 1'b1;
      @(negedge clk) valid_i = 1'b0;
      check(tag, res_o, e);
   endtask

   task automatic setup(input int s, input logic [7:0] i, input logic [1:0] z, input logic [1:0] v);
      @(negedge clk);
      lo = pat(s); hi = pat(s + 100); old = pat(s + 200);
      imm = i; esz = z; vl = v;
      mask = 32'hFFFF_FFFF; men = 1'b0; zen = 1'b0; bc = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 reset result", res_o, '0);
      check("R10 reset valid", DW'(valid_o), '0);
   endtask

   task automatic t_basic();
      setup(1, 8'd4, 2'd2, 2'd2);
      lo[63:0] = 64'h0000_0000_0000_00F0;
      hi[63:0] = 64'h0000_0000_0000_0001;
      run("R1 64-bit lanes shift 4");
      check("R1 hand lane0", DW'(res_o[63:0]), DW'(64'h1000_0000_0000_000F));
      setup(2, 8'd9, 2'd0, 2'd2);  run("R1 16-bit lanes shift 9");
      setup(3, 8'd17, 2'd1, 2'd2); run("R1 32-bit lanes shift 17");
   endtask

   task automatic t_count_mask();
      setup(4, 8'hC7, 2'd2, 2'd2); run("R2 64-bit imm high bits ignored");
      setup(5, 8'hFF, 2'd0, 2'd2); run("R2 16-bit count 15");
      setup(6, 8'hE5, 2'd1, 2'd3); run("R2 32-bit count 5, vl code 3");
   endtask

   task automatic t_mask();
      setup(7, 8'd3, 2'd1, 2'd2);
      men = 1'b1; mask = 32'h0000_A5C3;
      run("R3 32-bit lanes mask pattern merge");
      setup(8, 8'd11, 2'd3, 2'd2);
      men = 1'b1; mask = 32'hFFFF_FF5A;
      run("R3 esize code 3 as 64-bit, upper mask bits unused");
      setup(9, 8'd7, 2'd0, 2'd2);
      men = 1'b0; mask = 32'h0;
      run("R4 mask disabled writes all lanes");
   endtask

   task automatic t_zero_merge();
      setup(10, 8'd13, 2'd0, 2'd2);
      men = 1'b1; zen = 1'b1; mask = 32'h1234_8001;
      run("R5 zeroing masked lanes");
      setup(11, 8'd13, 2'd2, 2'd2);
      men = 1'b1; zen = 1'b0; mask = 32'h0000_0000;
      run("R6 merge keeps old destination");
   endtask

   task automatic t_bcast();
      setup(12, 8'd20, 2'd1, 2'd2); bc = 1'b1; run("R7 broadcast 32-bit");
      setup(13, 8'd40, 2'd2, 2'd2); bc = 1'b1; run("R7 broadcast 64-bit");
      setup(14, 8'd5, 2'd0, 2'd2);  bc = 1'b1; run("R8 broadcast ignored at 16-bit");
   endtask

   task automatic t_vlen();
      setup(15, 8'd6, 2'd0, 2'd0);
      men = 1'b1; zen = 1'b0; mask = 32'hFFFF_0000;
      run("R9 vl 128 clears upper, merge below");
      check("R9 upper bits zero", DW'(res_o[DW-1:128]), '0);
      setup(16, 8'd33, 2'd2, 2'd1); run("R9 vl 256 with 64-bit lanes");
   endtask

   task automatic t_pipe();
      logic [DW-1:0] prev;
      setup(17, 8'd2, 2'd1, 2'd2); run("R10 load");
      prev = res_o;
      lo = pat(99); hi = pat(98);
      @(negedge clk);
      check("R10 hold when idle", res_o, prev);
      check("R10 valid low when idle", DW'(valid_o), '0);
      @(negedge clk) valid_i = 1'b1;
      @(negedge clk);
      check("R10 valid echo", DW'(valid_o), DW'(1));
      valid_i = 1'b0;
   endtask

   task automatic t_zero_count();
      setup(18, 8'd64, 2'd2, 2'd2);
      run("R11 count zero returns lo source");
      check("R11 equals lo", res_o, lo);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      rst = 1'b1; valid_i = 1'b0;
      lo = '0; hi = '0; old = '0; imm = '0; esz = '0; vl = '0;
      mask = '0; men = 1'b0; zen = 1'b0; bc = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_basic();
      t_count_mask();
      t_mask();
      t_zero_merge();
      t_bcast();
      t_vlen();
      t_pipe();
      t_zero_count();
      finish_up();
   end
endmodule